// File: doc/BRIEF.md
# Dual-Page Circular DMA Ring Engine

This block moves 32-bit words between a line-rate framing source and system memory through two circular buffers. The fetch ring reads words from memory for transmission. The store ring writes received words to memory. Software gives each ring three byte addresses: its first word, a half-way word and its last word. It then sets the enable bit. Each single-cycle frame strobe moves one word on each ring. The current address steps by 4 after each word and returns to the first word after the last one.

Each ring works as two pages in alternation. One status bit fires when the half-way word has been moved and another fires when the last word has been moved, so software can refill or drain the page that has just completed. The current address of each ring can be read back. An address below the half-way word means the second page is the one free for software. In each word, byte lane 0 carries the first bearer and byte lane 1 the second. Software fills idle lanes with 0xFF. The engine moves whole words and does not interpret lanes.

Each memory side is a valid/ready request port. Once valid is raised, it stays high with a stable address (and stable write data) until ready is seen at a clock edge. The single exception is that clearing the enable bit withdraws the request. The transfer completes on the edge where valid and ready are both high. Read data must be presented with ready.

Top module: `ring_dma_engine`

## Requirements
- R1: After reset the enable bit, the interrupt mask and the status are 0, `irq` is low, no request is raised, and both current addresses are 0.
- R2: While enabled, each frame strobe that finds a ring idle raises one request at that ring's current address. Valid, address and write data then hold until ready is seen.
- R3: Each completed transfer advances that ring's current address by 4. The transfer of the word at the ring's end address instead reloads the start address.
- R4: Completing the word at the half-way address sets status bit 0 (fetch ring) or bit 2 (store ring). Completing the word at the end address sets bit 1 (fetch ring) or bit 3 (store ring).
- R5: Writing the status register (offset 2) clears each bit written as 1 and leaves bits written as 0 unchanged. A set event in the same cycle wins over the clear.
- R6: `irq` is high exactly when some status bit and the same bit of the 8-bit mask register (offset 1) are both 1. A mask of 0x0F enables the four page interrupts.
- R7: A frame strobe that arrives while the ring's request is still outstanding (including the cycle in which it is granted) starts no new transfer. It sets the sticky bit 4 (fetch underrun) or bit 5 (store overrun).
- R8: Bit 0 of the control register (offset 0) enables both rings. While that bit is 0, outstanding requests are withdrawn and each current address follows its start register.
- R9: A start address written while enabled leaves the current address unchanged and takes effect at the next wrap.
- R10: `tx_word` holds the last word read from memory, captured on its grant. `wr_data` carries the `rx_word` value sampled with the accepted frame strobe.
- R11: The register offsets are as follows. Offsets 3 to 5 hold the fetch ring's start, half-way and end addresses, and offsets 6 to 8 hold the same three for the store ring. Offsets 9 and 10 read the fetch and store current addresses. All other offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register offset for read and write |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on `cfg_addr`) |
| frame_tick | input | 1 | One-cycle strobe, one word per ring |
| rx_word | input | 32 | Received word, sampled with `frame_tick` |
| tx_word | output | 32 | Last word fetched for transmission |
| rd_valid | output | 1 | Fetch ring memory request |
| rd_ready | input | 1 | Memory grant for the fetch request |
| rd_addr | output | 32 | Fetch byte address |
| rd_data | input | 32 | Fetch data, valid with `rd_ready` |
| wr_valid | output | 1 | Store ring memory request |
| wr_ready | input | 1 | Memory grant for the store request |
| wr_addr | output | 32 | Store byte address |
| wr_data | output | 32 | Store data |
| irq | output | 1 | Masked interrupt |

## Verification
The assertions check on every cycle that a request holds its address until it is granted and that nothing is requested while disabled. They also check that a granted word moves the address by 4 or wraps it to the start, and that a strobe over an outstanding request raises the sticky flag. The bench scenarios cover the rest. These are the address sequence and data lanes through a full wrap, the half-way and end status bits, and write-one-to-clear with a zero write having no effect. They also cover masking, a start address moved during operation, and disabling with a request in flight.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;

  typedef enum logic [3:0] {
    RS_CTRL     = 4'd0,
    RS_MASK     = 4'd1,
    RS_STATUS   = 4'd2,
    RS_TX_START = 4'd3,
    RS_TX_MID   = 4'd4,
    RS_TX_END   = 4'd5,
    RS_RX_START = 4'd6,
    RS_RX_MID   = 4'd7,
    RS_RX_END   = 4'd8,
    RS_TX_CUR   = 4'd9,
    RS_RX_CUR   = 4'd10
  } reg_sel_e;

  localparam int NCH     = 2;   // 0: fetch ring, 1: store ring
  localparam int REGS_CH = 3;   // start, half-way, end per ring
  localparam int SW      = 8;   // status and mask width

  // status bit positions
  localparam int ST_TX_MID = 0;
  localparam int ST_TX_END = 1;
  localparam int ST_RX_MID = 2;
  localparam int ST_RX_END = 3;
  localparam int ST_TX_UR  = 4;
  localparam int ST_RX_OR  = 5;

endpackage

// File: rtl/ring_dma_chan.sv
module ring_dma_chan #(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter bit IS_WRITE = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] mid_addr,
  input  logic [AW-1:0] end_addr,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] word_in,
  output logic [DW-1:0] word_out,
  output logic [AW-1:0] cur_addr,
  output logic          hit_mid,
  output logic          hit_end,
  output logic          xrun
);
  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  logic          pend;
  logic [AW-1:0] cur;
  logic [DW-1:0] word_q;
  logic          fire, accept, cap;
  logic [DW-1:0] src;

  assign mem_valid = pend & en;
  assign mem_addr  = cur;
  assign cur_addr  = cur;
  assign word_out  = word_q;

  assign fire    = mem_valid & mem_ready;
  assign accept  = en & tick & ~pend;
  assign xrun    = en & tick & pend;
  assign hit_mid = fire & (cur == mid_addr);
  assign hit_end = fire & (cur == end_addr);

  // store ring captures at the strobe, fetch ring at the grant
  assign cap = IS_WRITE ? accept : fire;
  assign src = IS_WRITE ? word_in : mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      cur  <= '0;
    end else if (!en) begin
      pend <= 1'b0;
      cur  <= start_addr;
    end else begin
      if (fire) begin
        pend <= 1'b0;
        cur  <= hit_end ? start_addr : cur + STEP;
      end
      if (accept) pend <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   word_q <= '0;
    else if (cap) word_q <= src;
  end

endmodule

// File: rtl/ring_dma_regs.sv
module ring_dma_regs
  import ring_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [3:0]             cfg_addr,
  input  logic [DW-1:0]          cfg_wdata,
  output logic [DW-1:0]          cfg_rdata,
  input  logic [NCH-1:0][AW-1:0] cur_addr,
  input  logic [SW-1:0]          set_bits,
  output logic                   dma_en,
  output logic [NCH-1:0][AW-1:0] ring_start,
  output logic [NCH-1:0][AW-1:0] ring_mid,
  output logic [NCH-1:0][AW-1:0] ring_end,
  output logic [SW-1:0]          status,
  output logic                   irq
);
  logic [SW-1:0] irq_mask;
  logic [SW-1:0] clr_bits;

  assign clr_bits = (cfg_we && cfg_addr == RS_STATUS) ? cfg_wdata[SW-1:0] : '0;
  assign irq      = |(status & irq_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_en     <= 1'b0;
      irq_mask   <= '0;
      status     <= '0;
      ring_start <= '0;
      ring_mid   <= '0;
      ring_end   <= '0;
    end else begin
      if (cfg_we && cfg_addr == RS_CTRL) dma_en   <= cfg_wdata[0];
      if (cfg_we && cfg_addr == RS_MASK) irq_mask <= cfg_wdata[SW-1:0];
      for (int c = 0; c < NCH; c++) begin
        if (cfg_we && cfg_addr == 4'(RS_TX_START + REGS_CH*c)) ring_start[c] <= cfg_wdata[AW-1:0];
        if (cfg_we && cfg_addr == 4'(RS_TX_MID   + REGS_CH*c)) ring_mid[c]   <= cfg_wdata[AW-1:0];
        if (cfg_we && cfg_addr == 4'(RS_TX_END   + REGS_CH*c)) ring_end[c]   <= cfg_wdata[AW-1:0];
      end
      status <= (status & ~clr_bits) | set_bits;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      RS_CTRL:     cfg_rdata = DW'(dma_en);
      RS_MASK:     cfg_rdata = DW'(irq_mask);
      RS_STATUS:   cfg_rdata = DW'(status);
      RS_TX_START: cfg_rdata = DW'(ring_start[0]);
      RS_TX_MID:   cfg_rdata = DW'(ring_mid[0]);
      RS_TX_END:   cfg_rdata = DW'(ring_end[0]);
      RS_RX_START: cfg_rdata = DW'(ring_start[1]);
      RS_RX_MID:   cfg_rdata = DW'(ring_mid[1]);
      RS_RX_END:   cfg_rdata = DW'(ring_end[1]);
      RS_TX_CUR:   cfg_rdata = DW'(cur_addr[0]);
      RS_RX_CUR:   cfg_rdata = DW'(cur_addr[1]);
      default:     cfg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/ring_dma_engine.sv
module ring_dma_engine
  import ring_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          frame_tick,
  input  logic [DW-1:0] rx_word,
  output logic [DW-1:0] tx_word,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          irq
);
  logic                   dma_en;
  logic [NCH-1:0][AW-1:0] ring_start, ring_mid, ring_end, cur_addr, ch_addr;
  logic [NCH-1:0][DW-1:0] ch_rdata, ch_win, ch_wout;
  logic [NCH-1:0]         ch_valid, ch_ready, hit_mid, hit_end, xrun;
  logic [SW-1:0]          irq_status, set_bits;

  // per-ring memory side wiring: ring 0 reads, ring 1 writes
  assign ch_ready = {wr_ready, rd_ready};
  assign ch_rdata = {{DW{1'b0}}, rd_data};
  assign ch_win   = {rx_word, {DW{1'b0}}};

  assign rd_valid = ch_valid[0];
  assign rd_addr  = ch_addr[0];
  assign tx_word  = ch_wout[0];
  assign wr_valid = ch_valid[1];
  assign wr_addr  = ch_addr[1];
  assign wr_data  = ch_wout[1];

  always_comb begin
    set_bits            = '0;
    set_bits[ST_TX_MID] = hit_mid[0];
    set_bits[ST_TX_END] = hit_end[0];
    set_bits[ST_RX_MID] = hit_mid[1];
    set_bits[ST_RX_END] = hit_end[1];
    set_bits[ST_TX_UR]  = xrun[0];
    set_bits[ST_RX_OR]  = xrun[1];
  end

  ring_dma_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .cur_addr   (cur_addr),
    .set_bits   (set_bits),
    .dma_en     (dma_en),
    .ring_start (ring_start),
    .ring_mid   (ring_mid),
    .ring_end   (ring_end),
    .status     (irq_status),
    .irq        (irq)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ring
    ring_dma_chan #(.AW(AW), .DW(DW), .IS_WRITE(g == 1)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (dma_en),
      .tick       (frame_tick),
      .start_addr (ring_start[g]),
      .mid_addr   (ring_mid[g]),
      .end_addr   (ring_end[g]),
      .mem_valid  (ch_valid[g]),
      .mem_ready  (ch_ready[g]),
      .mem_addr   (ch_addr[g]),
      .mem_rdata  (ch_rdata[g]),
      .word_in    (ch_win[g]),
      .word_out   (ch_wout[g]),
      .cur_addr   (cur_addr[g]),
      .hit_mid    (hit_mid[g]),
      .hit_end    (hit_end[g]),
      .xrun       (xrun[g])
    );
  end

endmodule

// File: rtl/ring_dma_checker.sv
module ring_dma_checker #(
  parameter int AW = 32,
  parameter int SW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dma_en,
  input logic          frame_tick,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [AW-1:0] rd_addr,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [AW-1:0] tx_cur,
  input logic [AW-1:0] tx_start,
  input logic [AW-1:0] tx_end,
  input logic [SW-1:0] status
);

  a_r2_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> !dma_en || (rd_valid && $stable(rd_addr)));

  a_r2_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> !dma_en || (wr_valid && $stable(wr_addr)));

  a_r3_rd_step: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready && rd_addr != tx_end |=> tx_cur == $past(rd_addr) + AW'(4));

  a_r3_rd_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready && rd_addr == tx_end |=> tx_cur == $past(tx_start));

  a_r7_tx_underrun: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick && rd_valid |=> status[4]);

  a_r7_rx_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick && wr_valid |=> status[5]);

  a_r8_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |-> !rd_valid && !wr_valid);

endmodule

bind ring_dma_engine ring_dma_checker #(.AW(AW), .SW(ring_dma_pkg::SW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dma_en     (dma_en),
  .frame_tick (frame_tick),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .rd_addr    (rd_addr),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_addr    (wr_addr),
  .tx_cur     (cur_addr[0]),
  .tx_start   (ring_start[0]),
  .tx_end     (ring_end[0]),
  .status     (irq_status)
);

// File: tb/test_ring_dma_engine.sv
module test_ring_dma_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        frame_tick = 1'b0;
  logic [31:0] rx_word = '0;
  logic [31:0] tx_word;
  logic        rd_valid, wr_valid;
  logic        rd_ready, wr_ready;
  logic [31:0] rd_addr, wr_addr, rd_data, wr_data;
  logic        irq;
  logic        rdy_en = 1'b1;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int seq = 0;

  logic [31:0] exp_ra_q[$];
  logic [31:0] exp_wa_q[$];
  logic [31:0] exp_wd_q[$];
  logic [31:0] m_cur[2], m_start[2], m_end[2];

  always #2 clk = ~clk;   // 250 MHz

  function automatic logic [31:0] mem_pat(input logic [31:0] a);
    return {a[23:0], 8'h5A};
  endfunction

  assign rd_ready = rdy_en;
  assign wr_ready = rdy_en;
  assign rd_data  = rd_valid ? mem_pat(rd_addr) : 32'hFFFF_FFFF;

  ring_dma_engine i_ring_dma_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .frame_tick(frame_tick),
    .rx_word(rx_word), .tx_word(tx_word), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    cfg_addr = a;
    @(negedge clk);
    chk(tag, cfg_rdata, exp);
  endtask

  task automatic pulse(input logic [31:0] w);
    @(posedge clk); #1;
    frame_tick = 1'b1; rx_word = w;
    @(posedge clk); #1;
    frame_tick = 1'b0;
  endtask

  // driver: push the expected transfers, advance the model, strobe
  task automatic tick_word();
    logic [31:0] w;
    seq++;
    w = 32'hC0DE_0000 | 32'(seq);
    exp_ra_q.push_back(m_cur[0]);
    exp_wa_q.push_back(m_cur[1]);
    exp_wd_q.push_back(w);
    for (int c = 0; c < 2; c++)
      m_cur[c] = (m_cur[c] == m_end[c]) ? m_start[c] : m_cur[c] + 32'd4;
    pulse(w);
    @(posedge clk); #1;
  endtask

  // monitor: compare every granted transfer against the scoreboard
  logic        txchk = 1'b0;
  logic [31:0] txchk_a;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (txchk) begin
        chk("R10 tx_word", tx_word, mem_pat(txchk_a));
        txchk = 1'b0;
      end
      if (rd_valid && rd_ready) begin
        if (exp_ra_q.size() == 0) chk("R2 unexpected fetch", rd_addr, 32'hxxxx_xxxx);
        else chk("R3 fetch address", rd_addr, exp_ra_q.pop_front());
        txchk = 1'b1;
        txchk_a = rd_addr;
      end
      if (wr_valid && wr_ready) begin
        if (exp_wa_q.size() == 0) chk("R2 unexpected store", wr_addr, 32'hxxxx_xxxx);
        else begin
          chk("R3 store address", wr_addr, exp_wa_q.pop_front());
          chk("R10 store data", wr_data, exp_wd_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq low", 32'(irq), 32'd0);
    chk("R1 no request", 32'({rd_valid, wr_valid}), 32'd0);
    rd_chk(4'd2, 32'd0, "R1 status");
    rd_chk(4'd0, 32'd0, "R1 enable");
    rd_chk(4'd9, 32'd0, "R1 fetch address");

    // rings of 8 words
    m_start[0] = 32'h100; m_end[0] = 32'h11C;
    m_start[1] = 32'h200; m_end[1] = 32'h21C;
    wr_reg(4'd3, 32'h100); wr_reg(4'd4, 32'h10C); wr_reg(4'd5, 32'h11C);
    wr_reg(4'd6, 32'h200); wr_reg(4'd7, 32'h20C); wr_reg(4'd8, 32'h21C);
    rd_chk(4'd9, 32'h100, "R8 address follows start while off");
    rd_chk(4'd7, 32'h20C, "R11 half-way readback");
    rd_chk(4'd12, 32'd0, "R11 unused offset");
    m_cur[0] = 32'h100; m_cur[1] = 32'h200;
    wr_reg(4'd1, 32'h0F);
    wr_reg(4'd0, 32'h1);

    // first page
    for (int i = 0; i < 4; i++) tick_word();
    rd_chk(4'd2, 32'h05, "R4 half-way bits");
    chk("R6 irq on page", 32'(irq), 32'd1);
    rd_chk(4'd9, 32'h110, "R11 fetch current address");
    rd_chk(4'd10, 32'h210, "R11 store current address");

    wr_reg(4'd2, 32'h00);
    rd_chk(4'd2, 32'h05, "R5 zero write no effect");
    wr_reg(4'd2, 32'h01);
    rd_chk(4'd2, 32'h04, "R5 clear one bit");
    wr_reg(4'd2, 32'h04);
    rd_chk(4'd2, 32'h00, "R5 clear other bit");
    chk("R6 irq low when clear", 32'(irq), 32'd0);

    // second page with interrupts masked, then wrap
    wr_reg(4'd1, 32'h00);
    for (int i = 0; i < 4; i++) tick_word();
    rd_chk(4'd2, 32'h0A, "R4 end bits");
    chk("R6 masked irq", 32'(irq), 32'd0);
    rd_chk(4'd9, 32'h100, "R3 wrap to start");
    wr_reg(4'd1, 32'h02);
    @(negedge clk);
    chk("R6 single mask bit", 32'(irq), 32'd1);
    wr_reg(4'd2, 32'hFF);
    wr_reg(4'd1, 32'h0F);

    // strobe while a request is outstanding
    rdy_en = 1'b0;
    tick_word();
    pulse(32'hDEAD_BEEF);
    rd_chk(4'd2, 32'h30, "R7 sticky under/overrun");
    @(negedge clk);
    chk("R2 request held", 32'(rd_valid), 32'd1);
    chk("R2 address held", rd_addr, 32'h100);
    @(posedge clk); #1 rdy_en = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    rd_chk(4'd9, 32'h104, "R7 one transfer only");
    wr_reg(4'd2, 32'h30);

    // start moved while running
    wr_reg(4'd3, 32'h108); m_start[0] = 32'h108;
    wr_reg(4'd6, 32'h208); m_start[1] = 32'h208;
    rd_chk(4'd9, 32'h104, "R9 address unchanged on start write");
    for (int i = 0; i < 8; i++) tick_word();
    rd_chk(4'd9, 32'h10C, "R9 new start after wrap");
    rd_chk(4'd10, 32'h20C, "R9 store new start after wrap");

    // disable with a request in flight
    rdy_en = 1'b0;
    pulse(32'h1234_5678);
    wr_reg(4'd0, 32'h0);
    @(negedge clk);
    chk("R8 request withdrawn", 32'({rd_valid, wr_valid}), 32'd0);
    rd_chk(4'd9, 32'h108, "R8 address back to start");
    rdy_en = 1'b1;
    repeat (3) @(posedge clk);

    chk("R2 all fetches seen", 32'(exp_ra_q.size()), 32'd0);
    chk("R2 all stores seen", 32'(exp_wa_q.size()), 32'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule